// File: doc/BRIEF.md
# PCI Master Burst Command Selector

This block sits between a DMA engine and the PCI master state machine. For each bus-master transfer it receives a starting dword address, a length in dwords and a direction. It returns the 4-bit PCI bus command that fits where the transfer lies relative to cacheline boundaries, and a burst-length limit. It also holds the cache line size and the latency timer. The cache line size is checked when it is written. Any value that is not a legal power of two is stored as zero.

A second function counts bus tenure. When the master starts a transaction, a down-counter loads the latency timer value and then decrements once per clock. When the count has run out and the grant has been taken away, the block raises a stop request so that the master ends its burst at the next data phase. The master state machine reports the end of the transaction, and the count then stops mattering.

Top module: `pci_burst_cmd_sel`

## Requirements
- R1: Both registers reset to zero. A write with `cfg_sel`=0 stores the cache line size only if the value is 1, 2, 4, 8, 16, 32, 64 or 128; any other value is stored as 0. A read with `cfg_sel`=0 returns the stored value, and with `cfg_sel`=1 returns the latency timer exactly as written.
- R2: A read (`req_write`=0) of exactly one dword yields command 4'b0110.
- R3: A read longer than one dword whose first and last dwords lie in the same cacheline yields 4'b1110.
- R4: A read longer than one dword whose first and last dwords lie in different cachelines yields 4'b1100.
- R5: A write that starts on a cacheline boundary and whose length is a nonzero whole multiple of the line size yields 4'b1111.
- R6: Every other write of nonzero length yields 4'b0111.
- R7: While the stored cache line size is 0, only 4'b0110 (read) and 4'b0111 (write) are produced, for any length.
- R8: A zero-length request gives `rsp_err`=1, `rsp_cmd`=4'b0000 and `rsp_burst`=0.
- R9: `rsp_valid` is high for exactly the one cycle that follows a cycle with `req_valid` high. `rsp_burst` equals the length, clipped to the latency timer when that timer is nonzero.
- R10: `frame_start` loads the tenure counter with the latency timer value, and the counter then decrements each clock down to zero. `stop_req` is high only while a tenure is active, the counter is zero and `bus_gnt` is low. `xfer_done` ends the tenure, and `frame_start` wins when both inputs are high together.
- R11: A request in the same cycle as a cache line size write is decoded with the size that was stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the cache line size, 1 selects the latency timer |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| req_valid | input | 1 | Transfer request strobe |
| req_addr | input | ADDR_W | Starting dword address |
| req_len | input | LEN_W | Length in dwords |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Response strobe |
| rsp_cmd | output | 4 | Selected bus command |
| rsp_burst | output | LEN_W | Burst-length limit in dwords |
| rsp_err | output | 1 | Zero-length request flag |
| frame_start | input | 1 | Master begins a transaction |
| xfer_done | input | 1 | Master ends the transaction |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| stop_req | output | 1 | Master must end its burst |

## Verification
The overlap that matters is a write of the cache line size that lands in the same clock as a transfer request, because the decode could pick up either the old size or the new one. The bench drives both inputs in one cycle several times. Each time, it changes the size between values that lead to different commands for the same request, for example from 8 to 0 with an aligned eight-dword write. The scoreboard's expected value is computed with the size held before the write. A second overlap is `frame_start` and `xfer_done` together, which must leave a tenure active and able to raise `stop_req`.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    localparam logic [3:0] CMD_NONE = 4'b0000;
    localparam logic [3:0] CMD_RD   = 4'b0110;
    localparam logic [3:0] CMD_RDL  = 4'b1110;
    localparam logic [3:0] CMD_RDM  = 4'b1100;
    localparam logic [3:0] CMD_WR   = 4'b0111;
    localparam logic [3:0] CMD_WRI  = 4'b1111;

    typedef struct packed {
        logic [7:0] line_sz;
        logic [7:0] lat;
    } cfg_state_t;

    typedef struct packed {
        logic [7:0] cnt;
        logic       active;
    } tenure_state_t;
endpackage

// File: rtl/pbc_cfg_regs.sv
module pbc_cfg_regs
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] line_sz,
    output logic [7:0] lat
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (sel) begin
                st_d.lat = wdata;
            end else begin
                // any single set bit of an 8-bit value is at most 128
                st_d.line_sz = $onehot(wdata) ? wdata : 8'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_sz = st_q.line_sz;
    assign lat     = st_q.lat;
    assign rdata   = sel ? st_q.lat : st_q.line_sz;

    // R1: stored line size is always zero or a single power of two
    a_r1_line_sz_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.line_sz));
    // R1: an illegal write leaves zero behind
    a_r1_illegal_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && $countones(wdata) != 1) |=> (st_q.line_sz == 8'd0));
endmodule

// File: rtl/pbc_cmd_pick.sv
module pbc_cmd_pick
    import pbc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [7:0]        line_sz,
    input  logic [7:0]        lat,
    output logic              rsp_valid,
    output logic [3:0]        rsp_cmd,
    output logic [LEN_W-1:0]  rsp_burst,
    output logic              rsp_err
);
    typedef struct packed {
        logic             valid;
        logic [3:0]       cmd;
        logic [LEN_W-1:0] burst;
        logic             err;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    logic [ADDR_W-1:0] line_mask;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] len_ext;
    logic [LEN_W-1:0]  lat_ext;
    logic              size_zero;
    logic              spans_lines;
    logic              start_aligned;
    logic              len_whole;

    always_comb begin
        size_zero     = (line_sz == 8'd0);
        line_mask     = ADDR_W'(line_sz) - ADDR_W'(1);
        len_ext       = ADDR_W'(req_len);
        last_addr     = req_addr + len_ext - ADDR_W'(1);
        spans_lines   = ((req_addr ^ last_addr) & ~line_mask) != '0;
        start_aligned = (req_addr & line_mask) == '0;
        len_whole     = (len_ext & line_mask) == '0;
        lat_ext       = LEN_W'(lat);

        st_d       = '0;
        st_d.valid = req_valid;
        if (req_valid) begin
            if (req_len == '0) begin
                st_d.err = 1'b1;
                st_d.cmd = CMD_NONE;
            end else begin
                if (req_write) begin
                    st_d.cmd = (!size_zero && start_aligned && len_whole) ? CMD_WRI : CMD_WR;
                end else if (req_len == LEN_W'(1) || size_zero) begin
                    st_d.cmd = CMD_RD;
                end else begin
                    st_d.cmd = spans_lines ? CMD_RDM : CMD_RDL;
                end
                st_d.burst = (lat != 8'd0 && lat_ext < req_len) ? lat_ext : req_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_cmd   = st_q.cmd;
    assign rsp_burst = st_q.burst;
    assign rsp_err   = st_q.err;

    // R9: one response per request, in the following cycle
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8: zero length reports error and no command
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == '0) |=> (rsp_err && rsp_cmd == CMD_NONE));
    // R7: without a line size only plain commands appear
    a_r7_plain_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && line_sz == 8'd0 && req_len != '0)
            |=> (rsp_cmd == CMD_RD || rsp_cmd == CMD_WR));
    // R9: burst never exceeds the requested length
    a_r9_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_burst <= $past(req_len)));
endmodule

// File: rtl/pbc_tenure_timer.sv
module pbc_tenure_timer
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] lat,
    input  logic       frame_start,
    input  logic       xfer_done,
    input  logic       bus_gnt,
    output logic       stop_req
);
    tenure_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.cnt    = lat;
            st_d.active = 1'b1;
        end else begin
            if (st_q.cnt != 8'd0) st_d.cnt = st_q.cnt - 8'd1;
            if (xfer_done)        st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_req = st_q.active && (st_q.cnt == 8'd0) && !bus_gnt;

    // R10: a new tenure loads the programmed budget
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.cnt == $past(lat) && st_q.active));
    // R10: counter moves down by one while running
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && st_q.cnt != 8'd0) |=> (st_q.cnt == $past(st_q.cnt) - 8'd1));
    // R10: stop only while grant is removed
    a_r10_stop_needs_no_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !bus_gnt);
endmodule

// File: rtl/pci_burst_cmd_sel.sv
module pci_burst_cmd_sel
    import pbc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [3:0]        rsp_cmd,
    output logic [LEN_W-1:0]  rsp_burst,
    output logic              rsp_err,
    input  logic              frame_start,
    input  logic              xfer_done,
    input  logic              bus_gnt,
    output logic              stop_req
);
    logic [7:0] line_sz;
    logic [7:0] lat;

    pbc_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .line_sz (line_sz),
        .lat     (lat)
    );

    pbc_cmd_pick #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_write (req_write),
        .line_sz   (line_sz),
        .lat       (lat),
        .rsp_valid (rsp_valid),
        .rsp_cmd   (rsp_cmd),
        .rsp_burst (rsp_burst),
        .rsp_err   (rsp_err)
    );

    pbc_tenure_timer u_tenure (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat         (lat),
        .frame_start (frame_start),
        .xfer_done   (xfer_done),
        .bus_gnt     (bus_gnt),
        .stop_req    (stop_req)
    );

    // R5: invalidate command only with a line size in force (R11: size before the edge)
    a_r5_wri_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cmd == CMD_WRI) |-> ($past(line_sz) != 8'd0 && $past(req_write)));
    // R3: line-read command never for single dword
    a_r3_rdl_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cmd == CMD_RDL) |-> ($past(req_len) > LEN_W'(1)));
endmodule

// File: tb/pci_burst_cmd_sel_test.sv
module pci_burst_cmd_sel_test;
    localparam int ADDR_W = 30;
    localparam int LEN_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid;
    logic [3:0]        rsp_cmd;
    logic [LEN_W-1:0]  rsp_burst;
    logic              rsp_err;
    logic              frame_start = 1'b0;
    logic              xfer_done = 1'b0;
    logic              bus_gnt = 1'b1;
    logic              stop_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int unsigned m_cls = 0;
    int unsigned m_lat = 0;

    typedef struct {
        logic [3:0] cmd;
        int unsigned burst;
        logic err;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    pci_burst_cmd_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_burst(rsp_burst), .rsp_err(rsp_err),
        .frame_start(frame_start), .xfer_done(xfer_done), .bus_gnt(bus_gnt), .stop_req(stop_req)
    );

    function automatic int unsigned legal_size(int unsigned v);
        for (int k = 0; k < 8; k++) if (v == (1 << k)) return v;
        return 0;
    endfunction

    function automatic logic [3:0] model_cmd(int unsigned a, int unsigned n, bit wr, int unsigned c);
        if (n == 0) return 4'b0000;
        if (wr) begin
            if (c != 0 && (a % c) == 0 && (n % c) == 0) return 4'b1111;
            return 4'b0111;
        end
        if (n == 1 || c == 0) return 4'b0110;
        if ((a / c) == ((a + n - 1) / c)) return 4'b1110;
        return 4'b1100;
    endfunction

    function automatic int unsigned model_burst(int unsigned n, int unsigned l);
        if (n == 0) return 0;
        if (l != 0 && l < n) return l;
        return n;
    endfunction

    task automatic check(bit ok, string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_cmd == e.cmd, e.tag, rsp_cmd, e.cmd);
                check(rsp_burst == LEN_W'(e.burst), {e.tag, " burst R9"}, rsp_burst, e.burst);
                check(rsp_err == e.err, {e.tag, " err R8"}, rsp_err, e.err);
            end
        end
    end

    task automatic push_exp(int unsigned a, int unsigned n, bit wr, string tag);
        exp_t e;
        e.cmd   = model_cmd(a, n, wr, m_cls);
        e.burst = model_burst(n, m_lat);
        e.err   = (n == 0);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic cfg_write(bit sel, int unsigned v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel) m_lat = v; else m_cls = legal_size(v);
    endtask

    task automatic do_req(int unsigned a, int unsigned n, bit wr, string tag);
        @(negedge clk);
        push_exp(a, n, wr, tag);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(n); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R11: request and size write in the same cycle
    task automatic req_with_write(int unsigned a, int unsigned n, bit wr, int unsigned v, string tag);
        @(negedge clk);
        push_exp(a, n, wr, tag);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(n); req_write = wr;
        cfg_wr_en = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'(v);
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        m_cls = legal_size(v);
    endtask

    task automatic read_reg(bit sel, int unsigned exp, string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(cfg_rdata == 8'(exp), tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_reg(1'b0, 0, "R1 reset line size");
        read_reg(1'b1, 0, "R1 reset latency");
        check(rsp_valid == 1'b0, "R9 idle after reset", rsp_valid, 0);
        check(stop_req == 1'b0, "R10 idle after reset", stop_req, 0);

        // R1 sanitizing
        cfg_write(1'b0, 8);   read_reg(1'b0, 8,   "R1 legal 8");
        cfg_write(1'b0, 12);  read_reg(1'b0, 0,   "R1 illegal 12");
        cfg_write(1'b0, 128); read_reg(1'b0, 128, "R1 legal 128");
        cfg_write(1'b0, 255); read_reg(1'b0, 0,   "R1 illegal 255");
        cfg_write(1'b0, 1);   read_reg(1'b0, 1,   "R1 legal 1");
        cfg_write(1'b1, 200); read_reg(1'b1, 200, "R1 latency raw");
        cfg_write(1'b1, 0);

        // R7 size zero
        cfg_write(1'b0, 0);
        do_req(0, 16, 1'b1, "R7 write no size");
        do_req(3, 40, 1'b0, "R7 read no size");

        cfg_write(1'b0, 8);
        do_req(100, 1, 1'b0, "R2 single read");
        do_req(16, 8, 1'b0, "R3 read full line");
        do_req(17, 6, 1'b0, "R3 read inside line");
        do_req(20, 5, 1'b0, "R4 read crosses");
        do_req(0, 64, 1'b0, "R4 read many lines");
        do_req(8, 16, 1'b1, "R5 write two lines");
        do_req(64, 8, 1'b1, "R5 write one line");
        do_req(9, 8, 1'b1, "R6 write misaligned");
        do_req(8, 12, 1'b1, "R6 write partial");
        do_req(8, 1, 1'b1, "R6 write single");
        do_req(50, 0, 1'b0, "R8 zero read");
        do_req(50, 0, 1'b1, "R8 zero write");
        cfg_write(1'b0, 1);
        do_req(5, 2, 1'b0, "R4 read size one");
        do_req(5, 1, 1'b1, "R5 write size one");
        cfg_write(1'b0, 128);
        do_req(0, 128, 1'b1, "R5 write size 128");
        do_req(100, 28, 1'b0, "R3 read size 128");
        do_req(100, 29, 1'b0, "R4 read size 128");

        // R9 burst clipping
        cfg_write(1'b1, 10);
        do_req(0, 300, 1'b0, "R9 clipped");
        do_req(0, 7, 1'b1, "R9 under limit");

        // R11 overlap
        cfg_write(1'b0, 8);
        req_with_write(16, 8, 1'b1, 0, "R11 old size 8");
        req_with_write(16, 8, 1'b1, 8, "R11 old size 0");
        req_with_write(17, 6, 1'b0, 4, "R11 read old 8");

        // back-to-back requests
        @(negedge clk);
        push_exp(0, 8, 1'b1, "R5 b2b first");
        req_valid = 1'b1; req_addr = 0; req_len = 8; req_write = 1'b1;
        @(negedge clk);
        push_exp(3, 9, 1'b0, "R4 b2b second");
        req_addr = 3; req_len = 9; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R9 all responses seen", sb.size(), 0);

        // R10 tenure
        cfg_write(1'b1, 3);
        @(negedge clk);
        frame_start = 1'b1; bus_gnt = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        check(stop_req == 1'b0, "R10 count 3", stop_req, 0);
        @(negedge clk);
        check(stop_req == 1'b0, "R10 count 2", stop_req, 0);
        @(negedge clk);
        check(stop_req == 1'b0, "R10 count 1", stop_req, 0);
        @(negedge clk);
        check(stop_req == 1'b1, "R10 expired no grant", stop_req, 1);
        bus_gnt = 1'b1;
        #1;
        check(stop_req == 1'b0, "R10 expired with grant", stop_req, 0);
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; bus_gnt = 1'b0;
        #1;
        check(stop_req == 1'b0, "R10 tenure ended", stop_req, 0);
        // R10 frame_start wins over xfer_done, latency 0
        cfg_write(1'b1, 0);
        @(negedge clk);
        frame_start = 1'b1; xfer_done = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; xfer_done = 1'b0;
        #1;
        check(stop_req == 1'b1, "R10 start beats done", stop_req, 1);
        bus_gnt = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule